// File: doc/BRIEF.md
# Microsecond Compare Timer

A free-running 64-bit up-counter that advances by one on each cycle where the tick-enable input is high. With a 1 MHz tick, one count is one microsecond. Beside the counter sit several 32-bit compare channels, four by default. A channel raises its sticky match flag, and with it its own level-high interrupt line, on the tick where the low counter word becomes equal to the channel's compare value.

Software reads and writes the block through a simple 32-bit word-addressed register bus. Read data is returned in the same cycle. To arm a channel, software reads the low count, adds an interval and writes the sum into that channel's compare register. To acknowledge a channel, it writes a one to the channel's status bit. The counter cannot be written. Its reset value is a parameter, so the same block can start at any point of the 64-bit range.

Top module: `tcmp_timer`

## Requirements
- R1: During and after reset, the counter holds the RESET_COUNT parameter value, every compare register reads zero, every match flag is clear and every irq bit is low.
- R2: The 64-bit counter increases by exactly one at each clock edge where tick_en is high and holds its value at every other edge.
- R3: Reads are combinational on bus_word. Word 0 (byte 0x00) is status, with flag n on bit n and zeros above. Word 1 (0x04) is the low counter half. Word 2 (0x08) is the high counter half. Word 3+n (0x0C+4n) is compare n. Any other word reads zero.
- R4: On the tick where the low counter half steps from all ones to zero, the high half increments at that same edge.
- R5: Flag n sets at the clock edge where a tick moves the low counter half onto the value of compare n. After that edge the low half equals the compare value and the flag reads 1. A flag never sets at an edge without a tick.
- R6: A set flag stays set while the counter moves past the compare value, until software clears it.
- R7: A write to word 0 clears each flag whose data bit is 1. Zero bits leave their flag unchanged, and data bits at or above NUM_CH have no effect.
- R8: When a clear of flag n and a new match of channel n fall on the same edge, flag n ends set.
- R9: irq[n] is high in exactly the cycles where flag n is set.
- R10: A write to word 3+n loads compare n at that edge. The value reads back from the next cycle, and a match at that same edge is judged against the old compare value.
- R11: Writes to words 1 and 2 leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one pulse per microsecond |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | ADDR_W (3) | Register word index |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data, valid in the same cycle |
| irq | output | NUM_CH (4) | Per-channel level-high interrupt |

## Verification
The hardest event to reach from the ports is the low-word wrap, and with it the carry into the high half and a match against compare value zero. The counter cannot be written, so with a zero start this needs four billion ticks. The bench instead sets RESET_COUNT just 256 counts below a carry, then ticks through the wrap with channel 3 armed at zero. The set-over-clear collision needs a clear write on exactly the matching tick; the bench's own model of the counter tells it which cycle that is.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
   // Word indices on the register bus; compare channel n sits at CMP_BASE_WORD + n
   localparam int STAT_WORD     = 0;
   localparam int CNT_LO_WORD   = 1;
   localparam int CNT_HI_WORD   = 2;
   localparam int CMP_BASE_WORD = 3;
endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter #(
   parameter int                      HALF_W      = 32,
   parameter bit                      SPLIT_ADD   = 1'b1,
   parameter logic [2*HALF_W-1:0]     RESET_COUNT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   output logic [HALF_W-1:0] lo_o,
   output logic [HALF_W-1:0] hi_o,
   output logic [HALF_W-1:0] lo_next_o
);
   localparam int                 CNT_W    = 2 * HALF_W;
   localparam logic [CNT_W-1:0]   CNT_ONE  = CNT_W'(1);
   localparam logic [HALF_W-1:0]  HALF_ONE = HALF_W'(1);

   logic [HALF_W-1:0] lo_q;
   logic [HALF_W-1:0] hi_q;

   assign lo_next_o = lo_q + HALF_ONE;

   generate
      if (SPLIT_ADD) begin : g_split
         // two half-width adders, carry taken from the all-ones low half
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lo_q <= RESET_COUNT[HALF_W-1:0];
               hi_q <= RESET_COUNT[CNT_W-1:HALF_W];
            end else if (tick_i) begin
               lo_q <= lo_next_o;
               if (&lo_q) hi_q <= hi_q + HALF_ONE;
            end
         end
      end else begin : g_flat
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= RESET_COUNT;
            else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
         end
         assign lo_q = cnt_q[HALF_W-1:0];
         assign hi_q = cnt_q[CNT_W-1:HALF_W];
      end
   endgenerate

   assign lo_o = lo_q;
   assign hi_o = hi_q;

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> {hi_o, lo_o} == $past({hi_o, lo_o}) + CNT_ONE);
   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable({hi_o, lo_o}));
   // R4
   hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && (&lo_o)) |=> (hi_o == $past(hi_o) + HALF_ONE) && (lo_o == '0));
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic [W-1:0] cnt_next_i,
   input  logic         cmp_we_i,
   input  logic [W-1:0] wdata_i,
   input  logic         clr_i,
   output logic [W-1:0] cmp_o,
   output logic         flag_o
);
   logic [W-1:0] cmp_q;
   logic         flag_q;
   logic         hit;

   // the match looks at the value the counter is about to take
   assign hit = tick_i && (cnt_next_i == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q <= '0;
      else if (cmp_we_i) cmp_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign cmp_o  = cmp_q;
   assign flag_o = flag_q;

   // R10
   cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we_i |=> cmp_o == $past(wdata_i));
   // R5
   flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !tick_i) |=> !flag_o);
   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !tick_i) |=> !flag_o);
   // R8
   set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && tick_i && cnt_next_i == cmp_o) |=> flag_o);
endmodule

// File: rtl/tcmp_regif.sv
module tcmp_regif
   import tcmp_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 3,
   parameter int NUM_CH = 4
) (
   input  logic                         bus_en,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_word,
   input  logic [BUS_W-1:0]             bus_wdata,
   input  logic [NUM_CH-1:0]            flags_i,
   input  logic [BUS_W-1:0]             lo_i,
   input  logic [BUS_W-1:0]             hi_i,
   input  logic [NUM_CH-1:0][BUS_W-1:0] cmp_i,
   output logic [NUM_CH-1:0]            clr_o,
   output logic [NUM_CH-1:0]            cmp_we_o,
   output logic [BUS_W-1:0]             rdata_o
);
   logic wr;
   assign wr = bus_en && bus_we;

   assign clr_o = (wr && bus_word == ADDR_W'(STAT_WORD)) ? bus_wdata[NUM_CH-1:0] : '0;

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_we
         assign cmp_we_o[n] = wr && (bus_word == ADDR_W'(CMP_BASE_WORD + n));
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (bus_word == ADDR_W'(STAT_WORD))   rdata_o[NUM_CH-1:0] = flags_i;
      if (bus_word == ADDR_W'(CNT_LO_WORD)) rdata_o = lo_i;
      if (bus_word == ADDR_W'(CNT_HI_WORD)) rdata_o = hi_i;
      for (int n = 0; n < NUM_CH; n++) begin
         if (bus_word == ADDR_W'(CMP_BASE_WORD + n)) rdata_o = cmp_i[n];
      end
   end
endmodule

// File: rtl/tcmp_timer.sv
module tcmp_timer
   import tcmp_pkg::*;
#(
   parameter int                   BUS_W       = 32,
   parameter int                   NUM_CH      = 4,
   parameter int                   ADDR_W      = 3,
   parameter bit                   SPLIT_ADD   = 1'b1,
   parameter logic [2*BUS_W-1:0]   RESET_COUNT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_word,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int WORDS_NEEDED = CMP_BASE_WORD + NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > BUS_W) begin : g_bad_ch
         $error("tcmp_timer: NUM_CH must lie between 1 and BUS_W");
      end
      if (WORDS_NEEDED > (1 << ADDR_W)) begin : g_bad_addr
         $error("tcmp_timer: ADDR_W too narrow for the channel count");
      end
      if (BUS_W < 2) begin : g_bad_bus
         $error("tcmp_timer: BUS_W must be at least 2");
      end
   endgenerate

   logic [BUS_W-1:0]             cnt_lo;
   logic [BUS_W-1:0]             cnt_hi;
   logic [BUS_W-1:0]             cnt_lo_next;
   logic [NUM_CH-1:0]            flags;
   logic [NUM_CH-1:0]            clr;
   logic [NUM_CH-1:0]            cmp_we;
   logic [NUM_CH-1:0][BUS_W-1:0] cmp_val;

   tcmp_counter #(
      .HALF_W      (BUS_W),
      .SPLIT_ADD   (SPLIT_ADD),
      .RESET_COUNT (RESET_COUNT)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_en),
      .lo_o      (cnt_lo),
      .hi_o      (cnt_hi),
      .lo_next_o (cnt_lo_next)
   );

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         tcmp_channel #(.W(BUS_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_en),
            .cnt_next_i (cnt_lo_next),
            .cmp_we_i   (cmp_we[n]),
            .wdata_i    (bus_wdata),
            .clr_i      (clr[n]),
            .cmp_o      (cmp_val[n]),
            .flag_o     (flags[n])
         );
      end
   endgenerate

   tcmp_regif #(
      .BUS_W  (BUS_W),
      .ADDR_W (ADDR_W),
      .NUM_CH (NUM_CH)
   ) u_regif (
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_word  (bus_word),
      .bus_wdata (bus_wdata),
      .flags_i   (flags),
      .lo_i      (cnt_lo),
      .hi_i      (cnt_hi),
      .cmp_i     (cmp_val),
      .clr_o     (clr),
      .cmp_we_o  (cmp_we),
      .rdata_o   (bus_rdata)
   );

   assign irq = flags;

   // R10
   cmp_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmp_we));
   // R11
   cnt_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_word == ADDR_W'(CNT_LO_WORD) && !tick_en) |=> $stable(cnt_lo));
endmodule

// File: tb/tcmp_timer_tb.sv
module tcmp_timer_tb;
   localparam int          CLK_PERIOD = 10;
   localparam int          NCH = 4;
   localparam int          BW  = 32;
   localparam int          AW  = 3;
   localparam logic [63:0] RC  = 64'h0000_0001_FFFF_FF00;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tick_en, bus_en, bus_we;
   logic [AW-1:0] bus_word;
   logic [BW-1:0] bus_wdata, bus_rdata;
   logic [NCH-1:0] irq;

   tcmp_timer #(.BUS_W(BW), .NUM_CH(NCH), .ADDR_W(AW), .SPLIT_ADD(1'b1), .RESET_COUNT(RC)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_en(bus_en), .bus_we(bus_we),
      .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference state
   logic [63:0]    m_cnt;
   logic [31:0]    m_cmp [NCH];
   logic [NCH-1:0] m_flag;
   int    total = 0, bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   function automatic logic [31:0] m_read(logic [AW-1:0] w);
      logic [31:0] r = '0;
      if (w == 0) r[NCH-1:0] = m_flag;
      else if (w == 1) r = m_cnt[31:0];
      else if (w == 2) r = m_cnt[63:32];
      else if (int'(w) >= 3 && int'(w) < 3 + NCH) r = m_cmp[int'(w) - 3];
      return r;
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, check read data, advance model, check irq at next negedge
   task automatic step(bit tk, bit en, bit we, logic [AW-1:0] w, logic [31:0] d);
      logic [31:0]    nlo;
      logic [NCH-1:0] nf;
      logic [31:0]    ai, ei;
      tick_en = tk; bus_en = en; bus_we = we; bus_word = w; bus_wdata = d;
      #1;
      if (en && !we) chk("read data", bus_rdata, m_read(w));
      nlo = m_cnt[31:0] + 32'd1;
      nf  = m_flag;
      for (int n = 0; n < NCH; n++) begin
         if (tk && nlo == m_cmp[n])          nf[n] = 1'b1;
         else if (en && we && w == 0 && d[n]) nf[n] = 1'b0;
      end
      for (int n = 0; n < NCH; n++)
         if (en && we && int'(w) == 3 + n) m_cmp[n] = d;
      if (tk) m_cnt = m_cnt + 64'd1;
      m_flag = nf;
      @(negedge clk);
      ai = '0; ei = '0;
      ai[NCH-1:0] = irq; ei[NCH-1:0] = m_flag;
      chk("irq lines", ai, ei);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog (all R): actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] hi0;
      rst_n = 1'b0; tick_en = 0; bus_en = 0; bus_we = 0; bus_word = '0; bus_wdata = '0;
      m_cnt = RC; m_flag = '0;
      for (int n = 0; n < NCH; n++) m_cmp[n] = '0;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("irq in reset", {28'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int w = 0; w < 8; w++) step(0, 1, 0, AW'(w), 0);

      cur_req = "R11";
      step(0, 1, 1, 1, 32'hDEAD_BEEF);
      step(0, 1, 1, 2, 32'h1234_5678);
      step(0, 1, 0, 1, 0);
      step(0, 1, 0, 2, 0);

      cur_req = "R10";
      for (int n = 0; n < NCH; n++) step(0, 1, 1, AW'(3 + n), 32'hA5A5_0000 + n);
      for (int n = 0; n < NCH; n++) step(0, 1, 0, AW'(3 + n), 0);

      cur_req = "R2";
      for (int i = 0; i < 40; i++) step(i % 3 != 0, 1, 0, 1, 0);

      cur_req = "R5";
      step(0, 1, 1, 3, m_cnt[31:0] + 32'd5);
      step(0, 1, 1, 4, m_cnt[31:0]);          // equal now, but no tick: must stay clear
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);
      for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 0);

      cur_req = "R6";
      for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0);

      cur_req = "R7";
      step(0, 1, 1, 0, 32'h0);
      step(0, 1, 0, 0, 0);
      step(0, 1, 1, 0, 32'hFFFF_FFF0);
      step(0, 1, 0, 0, 0);
      step(0, 1, 1, 0, 32'h1);
      step(0, 1, 0, 0, 0);

      cur_req = "R8";
      step(0, 1, 1, 5, m_cnt[31:0] + 32'd4);
      while (m_cnt[31:0] + 32'd1 != m_cmp[2]) step(1, 1, 0, 0, 0);
      step(1, 1, 1, 0, 32'h4);
      step(0, 1, 0, 0, 0);
      step(0, 1, 1, 0, 32'h4);
      step(0, 1, 0, 0, 0);

      cur_req = "R4";
      step(0, 1, 1, 6, 32'h0);
      hi0 = m_cnt[63:32];
      for (int i = 0; i < 400 && m_cnt[63:32] == hi0; i++) step(1, 1, 0, 2, 0);
      step(0, 1, 0, 1, 0);
      step(0, 1, 0, 2, 0);
      chk("high half stepped", m_cnt[63:32], hi0 + 32'd1);

      cur_req = "R9";
      step(0, 1, 0, 0, 0);
      step(0, 1, 1, 0, 32'hF);
      step(0, 1, 0, 0, 0);

      cur_req = "R3";
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[3:0] < 4'd3)
            step(r[4], 1, 1, AW'(3 + (r[6:5] % NCH)), m_cnt[31:0] + {28'd0, r[10:7]});
         else if (r[3:0] == 4'd3)
            step(r[4], 1, 1, 0, {28'd0, r[14:11]});
         else
            step(r[4] | r[15], 1, 0, r[18:16], 0);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule